// File: doc/BRIEF.md
# Paged Breakpoint Address Comparator

This block watches every CPU bus cycle and raises a one-clock match pulse when the cycle hits a programmed breakpoint address. A bus cycle is presented as a one-way stream: `bus_valid` qualifies the address, page, page-active flag and direction of that cycle. The comparator never stalls, so there is no ready signal and no back-pressure. Every valid beat is consumed in the cycle it appears, and a beat that is not valid is simply not examined.

The width of the compared address depends on the cycle. When no program page is active, the whole 16-bit CPU address is compared. When a program page is active, the address becomes 20 bits wide: the 6-bit page value is joined to CPU address bits 13:0. Two mask bits can drop the low address byte, or drop both bytes and match on the page alone. The mask pattern that drops only the high byte is not a legal setting, and the logic treats it as a full compare. An optional direction qualifier restricts matches to reads only or to writes only.

A single write strobe loads all configuration fields together. The new values apply to bus cycles from the next clock onward.

Top module: `bkpt_match_top`

## Requirements
- R1: After synchronous reset, `hit` is 0 and every configuration field is 0. The block therefore starts with a full compare against address 0x0000 and page 0, and with direction qualification off.
- R2: `hit` is 1 in the cycle after a cycle where `bus_valid` is 1 and every enabled condition holds. It is 0 after any cycle where `bus_valid` is 0.
- R3: With `cfg_dir_en` = 0, a cycle can match whether it is a read or a write. The direction encoding is `bus_rd` = 1 for a read and 0 for a write.
- R4: With `cfg_dir_en` = 1, `cfg_dir_rd` = 0 lets only write cycles (`bus_rd` = 0) match, and `cfg_dir_rd` = 1 lets only read cycles (`bus_rd` = 1) match.
- R5: With `bus_paged` = 0 and a full compare, `bus_addr[15:8]` must equal `cfg_hi[7:0]` and `bus_addr[7:0]` must equal `cfg_lo`. The page input is ignored.
- R6: With `bus_paged` = 1 and a full compare, `bus_page` must equal `cfg_page`, `bus_addr[13:8]` must equal `cfg_hi[5:0]`, and `bus_addr[7:0]` must equal `cfg_lo`. The bits `bus_addr[15:14]` and `cfg_hi[7:6]` are ignored.
- R7: With mask setting {`cfg_mask_hi`,`cfg_mask_lo`} = 0:1, the low address byte is ignored. The high byte is still compared, and the page is also compared when `bus_paged` = 1.
- R8: Mask setting 1:0 is illegal. It behaves exactly like the full compare of setting 0:0.
- R9: With mask setting 1:1, a cycle with `bus_paged` = 1 matches whenever `bus_page` equals `cfg_page`, whatever the address. A cycle with `bus_paged` = 0 never matches.
- R10: A configuration write with `cfg_we` = 1 takes effect for bus cycles from the next clock. A bus cycle presented in the same clock as the write is compared against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_page | input | PAGE_W (6) | Breakpoint page value |
| cfg_hi | input | ADDR_W-8 (8) | Breakpoint high address byte |
| cfg_lo | input | 8 | Breakpoint low address byte |
| cfg_mask_hi | input | 1 | High-byte mask control |
| cfg_mask_lo | input | 1 | Low-byte mask control |
| cfg_dir_en | input | 1 | Enable direction qualification |
| cfg_dir_rd | input | 1 | Direction to match: 1 read, 0 write |
| bus_valid | input | 1 | Bus beat valid |
| bus_addr | input | ADDR_W (16) | CPU address |
| bus_page | input | PAGE_W (6) | Current page register value |
| bus_paged | input | 1 | Program page active for this cycle |
| bus_rd | input | 1 | Cycle direction: 1 read, 0 write |
| hit | output | 1 | Registered one-cycle match pulse |

## Verification
The bound checker inspects every pulse on `hit` against the beat that caused it, on every cycle. It confirms that the beat was valid, that the direction agreed with an enabled qualifier, that the page and the compared address bytes were equal for the mode in force, and that page-only mode never fired on an unpaged cycle. Other behaviours show up only in the bench scenarios. These are the reset defaults, the absence of a pulse where one must not appear, the illegal mask setting acting as a full compare, and the old settings applying to a beat that coincides with a configuration write.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // Raw {mask_hi, mask_lo} setting as programmed
  typedef enum logic [1:0] {
    MM_FULL     = 2'b00,
    MM_NO_LO    = 2'b01,
    MM_BAD_HI   = 2'b10,
    MM_PAGE_ONLY = 2'b11
  } mask_mode_e;

  // Effective compare controls after legalisation
  typedef struct packed {
    logic ign_hi;
    logic ign_lo;
    logic page_only;
  } mask_ctl_t;

  function automatic mask_ctl_t decode_mask(input logic mh, input logic ml);
    mask_ctl_t c;
    case (mask_mode_e'({mh, ml}))
      MM_NO_LO:     c = '{ign_hi: 1'b0, ign_lo: 1'b1, page_only: 1'b0};
      MM_PAGE_ONLY: c = '{ign_hi: 1'b1, ign_lo: 1'b1, page_only: 1'b1};
      default:      c = '{ign_hi: 1'b0, ign_lo: 1'b0, page_only: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs #(
  parameter int PAGE_W = 6,
  parameter int HI_W   = 8,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [HI_W-1:0]   cfg_hi,
  input  logic [LO_W-1:0]   cfg_lo,
  input  logic              cfg_mask_hi,
  input  logic              cfg_mask_lo,
  input  logic              cfg_dir_en,
  input  logic              cfg_dir_rd,
  output logic [PAGE_W-1:0] page_q,
  output logic [HI_W-1:0]   hi_q,
  output logic [LO_W-1:0]   lo_q,
  output logic              mask_hi_q,
  output logic              mask_lo_q,
  output logic              dir_en_q,
  output logic              dir_rd_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q    <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      mask_hi_q <= 1'b0;
      mask_lo_q <= 1'b0;
      dir_en_q  <= 1'b0;
      dir_rd_q  <= 1'b0;
    end else if (cfg_we) begin
      page_q    <= cfg_page;
      hi_q      <= cfg_hi;
      lo_q      <= cfg_lo;
      mask_hi_q <= cfg_mask_hi;
      mask_lo_q <= cfg_mask_lo;
      dir_en_q  <= cfg_dir_en;
      dir_rd_q  <= cfg_dir_rd;
    end
  end

endmodule

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 6,
  parameter int OFS_W  = 14
) (
  input  logic                 bus_paged,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [PAGE_W-1:0]    bus_page,
  input  logic [PAGE_W-1:0]    page_q,
  input  logic [ADDR_W-9:0]    hi_q,
  input  logic [7:0]           lo_q,
  input  logic                 mask_hi_q,
  input  logic                 mask_lo_q,
  output logic                 addr_ok
);
  import bkpt_pkg::*;

  localparam int BYTE_W = 8;
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam int PHI_W  = OFS_W - BYTE_W;

  mask_ctl_t  mc;
  logic [1:0] hi_eq_v;   // [0] unpaged width, [1] paged width
  logic       lo_eq;
  logic       page_eq;
  logic       hi_ok;
  logic       lo_ok;

  assign mc = decode_mask(mask_hi_q, mask_lo_q);

  // High-byte comparators: one per address width, selected by the page flag
  for (genvar g = 0; g < 2; g++) begin : g_hi
    localparam int W = (g == 0) ? HI_W : PHI_W;
    assign hi_eq_v[g] = (bus_addr[BYTE_W+W-1:BYTE_W] == hi_q[W-1:0]);
  end

  assign lo_eq   = (bus_addr[BYTE_W-1:0] == lo_q);
  assign page_eq = (bus_page == page_q);

  always_comb begin
    hi_ok = mc.ign_hi | hi_eq_v[bus_paged];
    lo_ok = mc.ign_lo | lo_eq;
    if (bus_paged) begin
      addr_ok = page_eq & hi_ok & lo_ok;
    end else begin
      addr_ok = ~mc.page_only & hi_ok & lo_ok;
    end
  end

endmodule

// File: rtl/bkpt_dir_qual.sv
module bkpt_dir_qual (
  input  logic dir_en_q,
  input  logic dir_rd_q,
  input  logic bus_rd,
  output logic dir_ok
);

  always_comb begin
    if (dir_en_q) begin
      dir_ok = (bus_rd == dir_rd_q);
    end else begin
      dir_ok = 1'b1;
    end
  end

endmodule

// File: rtl/bkpt_match_top.sv
module bkpt_match_top #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 6,
  parameter int OFS_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [ADDR_W-9:0] cfg_hi,
  input  logic [7:0]        cfg_lo,
  input  logic              cfg_mask_hi,
  input  logic              cfg_mask_lo,
  input  logic              cfg_dir_en,
  input  logic              cfg_dir_rd,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PAGE_W-1:0] bus_page,
  input  logic              bus_paged,
  input  logic              bus_rd,
  output logic              hit
);

  localparam int HI_W = ADDR_W - 8;

  logic [PAGE_W-1:0] page_q;
  logic [HI_W-1:0]   hi_q;
  logic [7:0]        lo_q;
  logic              mask_hi_q;
  logic              mask_lo_q;
  logic              dir_en_q;
  logic              dir_rd_q;
  logic              addr_ok;
  logic              dir_ok;
  logic              hit_q;

  bkpt_cfg_regs #(.PAGE_W(PAGE_W), .HI_W(HI_W), .LO_W(8)) cfg_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we),
    .cfg_page(cfg_page), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .cfg_mask_hi(cfg_mask_hi), .cfg_mask_lo(cfg_mask_lo),
    .cfg_dir_en(cfg_dir_en), .cfg_dir_rd(cfg_dir_rd),
    .page_q(page_q), .hi_q(hi_q), .lo_q(lo_q),
    .mask_hi_q(mask_hi_q), .mask_lo_q(mask_lo_q),
    .dir_en_q(dir_en_q), .dir_rd_q(dir_rd_q)
  );

  bkpt_addr_cmp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W)) cmp_i (
    .bus_paged(bus_paged), .bus_addr(bus_addr), .bus_page(bus_page),
    .page_q(page_q), .hi_q(hi_q), .lo_q(lo_q),
    .mask_hi_q(mask_hi_q), .mask_lo_q(mask_lo_q),
    .addr_ok(addr_ok)
  );

  bkpt_dir_qual dir_i (
    .dir_en_q(dir_en_q), .dir_rd_q(dir_rd_q), .bus_rd(bus_rd), .dir_ok(dir_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= bus_valid & addr_ok & dir_ok;
    end
  end

  assign hit = hit_q;

endmodule

// File: rtl/bkpt_match_chk.sv
module bkpt_match_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 6,
  parameter int OFS_W  = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_paged,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PAGE_W-1:0] bus_page,
  input logic [PAGE_W-1:0] cfg_page,
  input logic [ADDR_W-9:0] cfg_hi,
  input logic [7:0]        cfg_lo,
  input logic              mask_hi,
  input logic              mask_lo,
  input logic              dir_en,
  input logic              dir_rd,
  input logic              hit
);

  localparam int PHI_W = OFS_W - 8;

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(bus_valid)); // R2

  AST_DIR_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (hit && $past(dir_en) && !$past(dir_rd)) |-> !$past(bus_rd)); // R4

  AST_DIR_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    (hit && $past(dir_en) && $past(dir_rd)) |-> $past(bus_rd)); // R4

  AST_FLAT_HI_EQ: assert property (@(posedge clk) disable iff (rst)
    (hit && !$past(bus_paged)) |-> ($past(bus_addr[ADDR_W-1:8]) == $past(cfg_hi))); // R5

  AST_LO_EQ_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (hit && !$past(mask_lo)) |-> ($past(bus_addr[7:0]) == $past(cfg_lo))); // R8

  AST_PAGED_PAGE_EQ: assert property (@(posedge clk) disable iff (rst)
    (hit && $past(bus_paged)) |-> ($past(bus_page) == $past(cfg_page))); // R6

  AST_PAGED_OFS_EQ: assert property (@(posedge clk) disable iff (rst)
    (hit && $past(bus_paged) && !($past(mask_hi) && $past(mask_lo)))
      |-> ($past(bus_addr[OFS_W-1:8]) == $past(cfg_hi[PHI_W-1:0]))); // R6

  AST_PAGE_ONLY_NEEDS_PAGE: assert property (@(posedge clk) disable iff (rst)
    (hit && $past(mask_hi) && $past(mask_lo)) |-> $past(bus_paged)); // R9

endmodule

bind bkpt_match_top bkpt_match_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W)) chk_i (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_paged(bus_paged), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_page(bus_page), .cfg_page(page_q), .cfg_hi(hi_q), .cfg_lo(lo_q),
  .mask_hi(mask_hi_q), .mask_lo(mask_lo_q), .dir_en(dir_en_q), .dir_rd(dir_rd_q), .hit(hit)
);

// File: tb/bkpt_match_tb.sv
`timescale 1ns/1ps
module bkpt_match_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_page = '0;
  logic [7:0]  cfg_hi = '0;
  logic [7:0]  cfg_lo = '0;
  logic        cfg_mask_hi = 1'b0;
  logic        cfg_mask_lo = 1'b0;
  logic        cfg_dir_en = 1'b0;
  logic        cfg_dir_rd = 1'b0;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [5:0]  bus_page = '0;
  logic        bus_paged = 1'b0;
  logic        bus_rd = 1'b0;
  logic        hit;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bkpt_match_top dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_hi(cfg_hi),
    .cfg_lo(cfg_lo), .cfg_mask_hi(cfg_mask_hi), .cfg_mask_lo(cfg_mask_lo),
    .cfg_dir_en(cfg_dir_en), .cfg_dir_rd(cfg_dir_rd), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_page(bus_page), .bus_paged(bus_paged), .bus_rd(bus_rd),
    .hit(hit)
  );

  // Behavioural reference model
  int m_page, m_hi, m_lo;
  bit m_mh, m_ml, m_den, m_drd, m_hit;

  function automatic bit ref_hit(int a, int pg, bit pd, bit rd, bit v);
    bit hi_ok, lo_ok;
    if (!v) return 0;
    if (m_den && (rd != m_drd)) return 0;
    lo_ok = m_ml ? 1'b1 : ((a % 256) == m_lo);
    if (pd) begin
      if (pg != m_page) return 0;
      if (m_mh && m_ml) return 1;
      hi_ok = (((a / 256) % 64) == (m_hi % 64));
    end else begin
      if (m_mh && m_ml) return 0;
      hi_ok = ((a / 256) == m_hi);
    end
    return hi_ok && lo_ok;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_hit = 0; m_page = 0; m_hi = 0; m_lo = 0;
      m_mh = 0; m_ml = 0; m_den = 0; m_drd = 0;
    end else begin
      m_hit = ref_hit(int'(bus_addr), int'(bus_page), bus_paged, bus_rd, bus_valid);
      if (cfg_we) begin
        m_page = int'(cfg_page); m_hi = int'(cfg_hi); m_lo = int'(cfg_lo);
        m_mh = cfg_mask_hi; m_ml = cfg_mask_lo; m_den = cfg_dir_en; m_drd = cfg_dir_rd;
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: hit=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Model comparison on every clock (R2 pulse timing)
  always @(negedge clk) begin
    if (!rst && !done) chk(hit, m_hit, "R2 model");
  end

  task automatic cyc(input logic [15:0] a, input logic [5:0] pg, input bit pd,
                     input bit rd, input bit v, input bit exp, input string tag);
    bus_addr = a; bus_page = pg; bus_paged = pd; bus_rd = rd; bus_valid = v; cfg_we = 0;
    @(negedge clk);
    chk(hit, exp, tag);
  endtask

  task automatic wcfg(input logic [5:0] pg, input logic [7:0] hi, input logic [7:0] lo,
                      input bit mh, input bit ml, input bit den, input bit drd);
    cfg_page = pg; cfg_hi = hi; cfg_lo = lo; cfg_mask_hi = mh; cfg_mask_lo = ml;
    cfg_dir_en = den; cfg_dir_rd = drd; cfg_we = 1; bus_valid = 0;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hit, 0, "R1 hit low in reset");
    rst = 0;
    // R1 defaults: full compare against 0x0000, any direction
    cyc(16'h0000, 6'h00, 0, 0, 1, 1, "R1 default match 0x0000");
    cyc(16'h0001, 6'h00, 0, 1, 1, 0, "R1 default miss 0x0001");
    cyc(16'h0000, 6'h00, 0, 0, 0, 0, "R2 no valid no hit");

    wcfg(6'h2A, 8'h12, 8'h34, 0, 0, 0, 0);
    cyc(16'h1234, 6'h00, 0, 1, 1, 1, "R3 read matches");
    cyc(16'h1234, 6'h00, 0, 0, 1, 1, "R3 write matches");
    cyc(16'h1235, 6'h00, 0, 0, 1, 0, "R5 low byte differs");
    cyc(16'h1334, 6'h00, 0, 0, 1, 0, "R5 high byte differs");
    cyc(16'h1234, 6'h11, 0, 0, 1, 1, "R5 page ignored when unpaged");

    wcfg(6'h2A, 8'h12, 8'h34, 0, 0, 1, 0);
    cyc(16'h1234, 6'h00, 0, 0, 1, 1, "R4 write-only write");
    cyc(16'h1234, 6'h00, 0, 1, 1, 0, "R4 write-only read");
    wcfg(6'h2A, 8'h12, 8'h34, 0, 0, 1, 1);
    cyc(16'h1234, 6'h00, 0, 1, 1, 1, "R4 read-only read");
    cyc(16'h1234, 6'h00, 0, 0, 1, 0, "R4 read-only write");

    wcfg(6'h2A, 8'h12, 8'h34, 0, 0, 0, 0);
    cyc(16'hD234, 6'h2A, 1, 0, 1, 1, "R6 paged match, bits 15:14 ignored");
    cyc(16'h1234, 6'h2B, 1, 0, 1, 0, "R6 page differs");
    cyc(16'h1334, 6'h2A, 1, 0, 1, 0, "R6 offset differs");
    wcfg(6'h2A, 8'hD2, 8'h34, 0, 0, 0, 0);
    cyc(16'h1234, 6'h2A, 1, 1, 1, 1, "R6 cfg_hi 7:6 ignored when paged");
    cyc(16'h1234, 6'h2A, 0, 1, 1, 0, "R5 unpaged uses all 8 high bits");
    cyc(16'hD234, 6'h00, 0, 1, 1, 1, "R5 unpaged full match");

    wcfg(6'h2A, 8'h12, 8'h34, 0, 1, 0, 0);
    cyc(16'h12FF, 6'h00, 0, 0, 1, 1, "R7 low byte ignored");
    cyc(16'h13FF, 6'h00, 0, 0, 1, 0, "R7 high byte still checked");
    cyc(16'h12AB, 6'h2A, 1, 0, 1, 1, "R7 paged low ignored");
    cyc(16'h12AB, 6'h2B, 1, 0, 1, 0, "R7 paged page checked");

    wcfg(6'h2A, 8'h12, 8'h34, 1, 0, 0, 0);
    cyc(16'h1234, 6'h00, 0, 0, 1, 1, "R8 illegal mask full match");
    cyc(16'h9934, 6'h00, 0, 0, 1, 0, "R8 high byte not masked");
    cyc(16'h1299, 6'h00, 0, 0, 1, 0, "R8 low byte compared");
    cyc(16'h0034, 6'h2A, 1, 0, 1, 0, "R8 paged offset compared");

    wcfg(6'h2A, 8'h12, 8'h34, 1, 1, 0, 0);
    cyc(16'hFFFF, 6'h2A, 1, 1, 1, 1, "R9 page-only any address");
    cyc(16'h1234, 6'h2B, 1, 1, 1, 0, "R9 page-only wrong page");
    cyc(16'h1234, 6'h2A, 0, 1, 1, 0, "R9 never when unpaged");

    // R10: a write and a bus beat in the same clock use the old setting
    wcfg(6'h00, 8'h12, 8'h34, 0, 0, 0, 0);
    cfg_page = 0; cfg_hi = 8'h56; cfg_lo = 8'h78; cfg_mask_hi = 0; cfg_mask_lo = 0;
    cfg_dir_en = 0; cfg_dir_rd = 0; cfg_we = 1;
    bus_addr = 16'h1234; bus_page = 0; bus_paged = 0; bus_rd = 0; bus_valid = 1;
    @(negedge clk);
    chk(hit, 1, "R10 same-cycle beat uses old config");
    cyc(16'h5678, 6'h00, 0, 0, 1, 1, "R10 new config next cycle");
    cyc(16'h1234, 6'h00, 0, 0, 1, 0, "R10 old address no longer matches");

    // Mixed traffic against the reference model
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      if ($urandom_range(0, 7) == 0) begin
        cfg_page = 6'($urandom_range(0, 3)); cfg_hi = 8'($urandom_range(0, 255));
        cfg_lo = 8'($urandom_range(0, 255)); cfg_mask_hi = 1'($urandom_range(0, 1));
        cfg_mask_lo = 1'($urandom_range(0, 1)); cfg_dir_en = 1'($urandom_range(0, 1));
        cfg_dir_rd = 1'($urandom_range(0, 1)); cfg_we = 1;
      end else begin
        cfg_we = 0;
      end
      a = 16'($urandom_range(0, 65535));
      if ($urandom_range(0, 1) == 1) a = {a[15:14], 6'(m_hi), 8'(m_lo)};
      if ($urandom_range(0, 2) == 0) a[15:8] = 8'(m_hi);
      bus_addr = a; bus_page = 6'($urandom_range(0, 3));
      bus_paged = 1'($urandom_range(0, 1)); bus_rd = 1'($urandom_range(0, 1));
      bus_valid = ($urandom_range(0, 4) != 0);
      @(negedge clk);
    end
    cfg_we = 0; bus_valid = 0;
    @(negedge clk);

    done = 1;
    summary();
    $finish;
  end

endmodule